// File: doc/BRIEF.md
# Stepped Gain Ramp Controller with Soft Mute

This block keeps an 8-bit attenuation code for each of two audio channels and produces the gain code that is applied to each channel at each moment. Code X from 1 to 255 stands for a gain of 0.5·(X−255) dB, and code 0 stands for full silence. The applied gain does not jump to a new setting. It walks toward its target one code (0.5 dB) at a time, and it takes one such step every STEP_SAMPLES sample strobes.

Codes are double-buffered. A write always lands in the addressed channel's holding register. Only a write with the load bit set copies both holding registers into the active targets, so both channels can change on the same cycle. Several other controls act on the targets:

- A common-control input makes the left code the target for both channels.
- Soft mute, from a register bit or an active-low pin, ramps both gains to zero without touching the stored codes.
- An operation-disable input forces both gain outputs to zero at once.

A run detector watches the incoming sample pairs and raises a zero flag after a long unbroken run of silent pairs. When zero detection is enabled, the flag also drives the analogue-mute output.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: After reset both holding codes, both active targets and both gain outputs equal 0xFF. An active code of 0x00 ramps the gain down to 0x00 and holds it there.
- R2: A write (`wr_en`=1) with `wr_load`=0 stores `wr_code` in the channel picked by `wr_sel` (0 = left, 1 = right) and leaves both targets and both gains unchanged.
- R3: A write with `wr_load`=1 stores its code, then makes both holding codes (including the one just written) the active targets.
- R4: Each gain output moves exactly one code toward its target on every STEP_SAMPLES-th sample strobe (default 128), counted from reset. It does not move on any other cycle.
- R5: A target change during a ramp continues the ramp from the present gain value, one code per step, with no jump.
- R6: While `common_sel`=1 the right channel's target is the left active code. When `common_sel` returns to 0, the right gain returns to its own code.
- R7: Soft mute is active when `mute_bit`=1 or `mute_pin_n`=0. While it is active, both gains ramp to 0x00. After release they ramp back to the stored codes, which soft mute leaves unaltered.
- R8: `an_mute` is 1 while soft mute is active and both gains are 0x00. A gain of 0x00 reached with soft mute inactive does not set it.
- R9: `op_disable`=1 forces both gain outputs to 0x00 and `an_mute` to 1 in the same cycle. The ramp state is kept, so the previous gains reappear when `op_disable` returns to 0.
- R10: `zero_flag` rises after ZERO_RUN (default 1024) consecutive strobes in which both samples are zero. The first strobe with a non-zero sample on either channel clears it. `an_mute` follows `zero_flag` only while `zero_det_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Code write strobe |
| wr_sel | input | 1 | Write target channel: 0 left, 1 right |
| wr_code | input | 8 | Attenuation code to write |
| wr_load | input | 1 | When 1, the write also commits both held codes as targets |
| common_sel | input | 1 | Right channel follows the left code |
| mute_bit | input | 1 | Soft mute request, active high |
| mute_pin_n | input | 1 | Soft mute request, active low |
| op_disable | input | 1 | Forces gain outputs to zero |
| zero_det_en | input | 1 | Lets the zero run drive `an_mute` |
| sample_stb | input | 1 | One pulse per sample period |
| left_sample | input | 24 | Left sample for zero detection |
| right_sample | input | 24 | Right sample for zero detection |
| gain_left | output | 8 | Applied left gain code |
| gain_right | output | 8 | Applied right gain code |
| an_mute | output | 1 | Analogue mute flag |
| zero_flag | output | 1 | Zero run detected |

## Verification
The gain outputs change on the clock edge of the strobe that completes a step period. That is the 128th strobe after the previous step, with no further delay, so the bench drives strobes in exact multiples of 128 (and 127 plus 1 once) and samples on the falling edge right after the last strobe. `zero_flag` is registered and appears after the edge of the 1024th silent strobe. It clears after the edge of the first non-zero strobe. `op_disable`, `zero_det_en` and the mute gating reach `an_mute` and the gains within the same cycle, so those checks sample on the next falling edge. Expected gains are computed as start value moved by the number of elapsed steps, limited at the target.

// File: rtl/gain_ramp_pkg.sv
`timescale 1ns/1ps
package gain_ramp_pkg;
   localparam int NUM_CH = 2;
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;
endpackage

// File: rtl/gr_code_bank.sv
`timescale 1ns/1ps
module gr_code_bank
   import gain_ramp_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  chan_e                          wr_sel,
   input  logic [CODE_W-1:0]              wr_code,
   input  logic                           wr_load,
   input  logic                           common_sel,
   output logic [NUM_CH-1:0][CODE_W-1:0]  tgt_code
);
   logic [NUM_CH-1:0][CODE_W-1:0] hold_q, hold_nxt, act_q;

   always_comb begin
      hold_nxt = hold_q;
      if (wr_en) hold_nxt[wr_sel] = wr_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '1;
         act_q  <= '1;
      end else begin
         hold_q <= hold_nxt;
         if (wr_en && wr_load) act_q <= hold_nxt;
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tgt
      if (ch == int'(CH_LEFT)) begin : g_own
         assign tgt_code[ch] = act_q[ch];
      end else begin : g_shared
         assign tgt_code[ch] = common_sel ? act_q[CH_LEFT] : act_q[ch];
      end
   end
endmodule

// File: rtl/gr_step_timer.sv
`timescale 1ns/1ps
module gr_step_timer #(
   parameter int STEP_SAMPLES = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_stb,
   output logic step_tick
);
   if (STEP_SAMPLES == 1) begin : g_every
      assign step_tick = sample_stb;
   end else begin : g_count
      localparam int CNT_W = $clog2(STEP_SAMPLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_SAMPLES - 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt_q <= '0;
         else if (sample_stb) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      assign step_tick = sample_stb && (cnt_q == LAST);
   end
endmodule

// File: rtl/gr_ramp_chan.sv
`timescale 1ns/1ps
module gr_ramp_chan #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_tick,
   input  logic              soft_mute,
   input  logic [CODE_W-1:0] target,
   output logic [CODE_W-1:0] applied
);
   logic [CODE_W-1:0] goal;
   assign goal = soft_mute ? '0 : target;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) applied <= '1;
      else if (step_tick) begin
         if (applied < goal)      applied <= applied + 1'b1;
         else if (applied > goal) applied <= applied - 1'b1;
      end
   end
endmodule

// File: rtl/gr_zero_run.sv
`timescale 1ns/1ps
module gr_zero_run #(
   parameter int SAMPLE_W = 24,
   parameter int ZERO_RUN = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_stb,
   input  logic [SAMPLE_W-1:0] left_sample,
   input  logic [SAMPLE_W-1:0] right_sample,
   output logic                run_done
);
   localparam int RUN_W = $clog2(ZERO_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ZERO_RUN);
   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (sample_stb) begin
         if ((left_sample != '0) || (right_sample != '0)) run_q <= '0;
         else if (run_q != RUN_MAX)                       run_q <= run_q + 1'b1;
      end
   end
   assign run_done = (run_q == RUN_MAX);
endmodule

// File: rtl/gain_ramp_ctrl.sv
`timescale 1ns/1ps
module gain_ramp_ctrl
   import gain_ramp_pkg::*;
#(
   parameter int CODE_W       = 8,
   parameter int SAMPLE_W     = 24,
   parameter int STEP_SAMPLES = 128,
   parameter int ZERO_RUN     = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic [CODE_W-1:0]   wr_code,
   input  logic                wr_load,
   input  logic                common_sel,
   input  logic                mute_bit,
   input  logic                mute_pin_n,
   input  logic                op_disable,
   input  logic                zero_det_en,
   input  logic                sample_stb,
   input  logic [SAMPLE_W-1:0] left_sample,
   input  logic [SAMPLE_W-1:0] right_sample,
   output logic [CODE_W-1:0]   gain_left,
   output logic [CODE_W-1:0]   gain_right,
   output logic                an_mute,
   output logic                zero_flag
);
   if (CODE_W < 2)       begin : g_bad_code   $error("CODE_W must be at least 2");       end
   if (SAMPLE_W < 1)     begin : g_bad_sample $error("SAMPLE_W must be at least 1");     end
   if (STEP_SAMPLES < 1) begin : g_bad_step   $error("STEP_SAMPLES must be at least 1"); end
   if (ZERO_RUN < 1)     begin : g_bad_run    $error("ZERO_RUN must be at least 1");     end

   logic [NUM_CH-1:0][CODE_W-1:0] tgt_code, applied;
   logic step_tick, soft_mute, all_zero;

   assign soft_mute = mute_bit || !mute_pin_n;

   gr_code_bank #(.CODE_W(CODE_W)) u_bank (
      .clk, .rst_n, .wr_en,
      .wr_sel(chan_e'(wr_sel)),
      .wr_code, .wr_load, .common_sel,
      .tgt_code
   );

   gr_step_timer #(.STEP_SAMPLES(STEP_SAMPLES)) u_timer (
      .clk, .rst_n, .sample_stb, .step_tick
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      gr_ramp_chan #(.CODE_W(CODE_W)) u_ramp (
         .clk, .rst_n, .step_tick, .soft_mute,
         .target(tgt_code[ch]),
         .applied(applied[ch])
      );
   end

   gr_zero_run #(.SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) u_zero (
      .clk, .rst_n, .sample_stb, .left_sample, .right_sample,
      .run_done(zero_flag)
   );

   assign all_zero   = (applied[CH_LEFT] == '0) && (applied[CH_RIGHT] == '0);
   assign gain_left  = op_disable ? '0 : applied[CH_LEFT];
   assign gain_right = op_disable ? '0 : applied[CH_RIGHT];
   assign an_mute    = op_disable || (soft_mute && all_zero) || (zero_det_en && zero_flag);
endmodule

// File: rtl/gain_ramp_ctrl_chk.sv
`timescale 1ns/1ps
module gain_ramp_ctrl_chk #(
   parameter int CODE_W   = 8,
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_stb,
   input logic                op_disable,
   input logic [SAMPLE_W-1:0] left_sample,
   input logic [SAMPLE_W-1:0] right_sample,
   input logic [CODE_W-1:0]   gain_left,
   input logic [CODE_W-1:0]   gain_right,
   input logic                an_mute,
   input logic                zero_flag
);
   // R4 R5
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_disable && !$past(op_disable)) |->
         (gain_left == $past(gain_left)
          || {1'b0, gain_left} == {1'b0, $past(gain_left)} + 1'b1
          || {1'b0, $past(gain_left)} == {1'b0, gain_left} + 1'b1)
      && (gain_right == $past(gain_right)
          || {1'b0, gain_right} == {1'b0, $past(gain_right)} + 1'b1
          || {1'b0, $past(gain_right)} == {1'b0, gain_right} + 1'b1));

   // R4
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sample_stb) && !$past(op_disable) && !op_disable) |->
         ($stable(gain_left) && $stable(gain_right)));

   // R9
   op_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_disable |-> (gain_left == '0 && gain_right == '0 && an_mute));

   // R10
   zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sample_stb) && ($past(left_sample) != '0 || $past(right_sample) != '0))
         |-> !zero_flag);
endmodule

bind gain_ramp_ctrl gain_ramp_ctrl_chk #(.CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/gain_ramp_ctrl_bench.sv
`timescale 1ns/1ps
module gain_ramp_ctrl_bench;
   localparam int STEP = 128;
   localparam int RUN  = 1024;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, wr_sel = 0, wr_load = 0, common_sel = 0, mute_bit = 0;
   logic mute_pin_n = 1, op_disable = 0, zero_det_en = 0, sample_stb = 0;
   logic [7:0]  wr_code = 0;
   logic [23:0] left_sample = 0, right_sample = 0;
   logic [7:0]  gain_left, gain_right;
   logic        an_mute, zero_flag;
   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gain_ramp_ctrl u_gain_ramp_ctrl (.*);

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] code, input logic load);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_code = code; wr_load = load;
      @(negedge clk);
      wr_en = 0; wr_load = 0;
   endtask

   task automatic run(input int n, input logic [23:0] l, input logic [23:0] r);
      @(negedge clk);
      sample_stb = 1; left_sample = l; right_sample = r;
      repeat (n) @(posedge clk);
      @(negedge clk);
      sample_stb = 0;
   endtask

   task automatic gains(input string tag, input int el, input int er);
      chk({tag, " left"}, gain_left, el);
      chk({tag, " right"}, gain_right, er);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      gains("R1 reset", 8'hFF, 8'hFF);
      chk("R1 reset an_mute", an_mute, 0);
      chk("R1 reset zero_flag", zero_flag, 0);

      wr(0, 8'hF0, 0);
      run(2*STEP, 24'h123, 24'h456);
      gains("R2 staged only", 8'hFF, 8'hFF);

      wr(1, 8'hF8, 1);
      run(STEP-1, 24'h123, 24'h456);
      gains("R4 before step", 8'hFF, 8'hFF);
      run(1, 24'h123, 24'h456);
      gains("R4 first step", 8'hFE, 8'hFE);
      run(5*STEP, 24'h123, 24'h456);
      gains("R3 both loaded", 8'hF9, 8'hF9);
      run(2*STEP, 24'h123, 24'h456);
      gains("R3 right at target", 8'hF7, 8'hF8);

      wr(0, 8'hFA, 1);
      run(3*STEP, 24'h123, 24'h456);
      chk("R5 redirect", gain_left, 8'hFA);
      run(STEP, 24'h123, 24'h456);
      chk("R5 redirect hold", gain_left, 8'hFA);

      common_sel = 1;
      run(2*STEP, 24'h123, 24'h456);
      gains("R6 common", 8'hFA, 8'hFA);
      common_sel = 0;
      run(2*STEP, 24'h123, 24'h456);
      gains("R6 individual", 8'hFA, 8'hF8);

      wr(0, 8'h10, 0);
      wr(1, 8'h08, 1);
      run(250*STEP, 24'h123, 24'h456);
      gains("R3 long ramp", 8'h10, 8'h08);

      mute_bit = 1;
      run(8*STEP, 24'h123, 24'h456);
      gains("R7 mute bit partial", 8'h08, 8'h00);
      chk("R8 one channel nonzero", an_mute, 0);
      run(8*STEP, 24'h123, 24'h456);
      gains("R7 mute bit done", 8'h00, 8'h00);
      chk("R8 muted at zero", an_mute, 1);
      mute_bit = 0;
      run(4*STEP, 24'h123, 24'h456);
      gains("R7 release partial", 8'h04, 8'h04);
      chk("R8 released", an_mute, 0);
      run(12*STEP, 24'h123, 24'h456);
      gains("R7 restored", 8'h10, 8'h08);

      mute_pin_n = 0;
      run(16*STEP, 24'h123, 24'h456);
      gains("R7 mute pin", 8'h00, 8'h00);
      chk("R8 pin muted", an_mute, 1);
      mute_pin_n = 1;
      run(16*STEP, 24'h123, 24'h456);
      gains("R7 pin restored", 8'h10, 8'h08);

      @(negedge clk); op_disable = 1;
      @(negedge clk);
      gains("R9 forced", 8'h00, 8'h00);
      chk("R9 an_mute", an_mute, 1);
      run(STEP, 24'h123, 24'h456);
      gains("R9 forced hold", 8'h00, 8'h00);
      op_disable = 0;
      @(negedge clk);
      gains("R9 released", 8'h10, 8'h08);
      chk("R9 an_mute released", an_mute, 0);

      wr(0, 8'h00, 1);
      run(16*STEP, 24'h123, 24'h456);
      gains("R1 code zero", 8'h00, 8'h08);
      chk("R8 zero without mute", an_mute, 0);

      zero_det_en = 1;
      run(RUN-1, 0, 0);
      chk("R10 short run flag", zero_flag, 0);
      chk("R10 short run an_mute", an_mute, 0);
      run(1, 0, 0);
      chk("R10 full run flag", zero_flag, 1);
      chk("R10 full run an_mute", an_mute, 1);
      run(1, 0, 24'h1);
      chk("R10 right nonzero clears", zero_flag, 0);
      chk("R10 an_mute clears", an_mute, 0);
      zero_det_en = 0;
      run(RUN, 0, 0);
      chk("R10 flag without enable", zero_flag, 1);
      chk("R10 gated an_mute", an_mute, 0);
      zero_det_en = 1;
      @(negedge clk);
      chk("R10 enable an_mute", an_mute, 1);
      run(1, 24'h800000, 0);
      chk("R10 left nonzero clears", zero_flag, 0);
      run(600, 0, 0);
      run(1, 24'h2, 0);
      run(RUN-24, 0, 0);
      chk("R10 broken run", zero_flag, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule